// File: doc/BRIEF.md
# PCI Interrupt Router and CPU Line Trigger

This block turns an interrupt event from a PCI device into a change on a single CPU interrupt line. Each event carries the device-function number of the requester and the number of the interrupt pin it uses (0 to 3 for pins A to D). The block takes the slot from the device-function number and translates slot and pin into a mapped interrupt number through a fixed, slot-dependent table whose internal numbers start at 32. It reports that number on its output and updates the CPU line.

The internal index is the mapped number minus 32. Two 32-bit configuration words, one for trigger mode and one for polarity, are indexed by it. If the trigger-mode bit is set, the event fires a one-clock pulse on the CPU line. Otherwise the line takes the value of the polarity bit and holds it until the next event that is not ignored.

Events arrive on a valid/ready input. The block never applies back-pressure: `evt_ready` is high at all times, and every cycle with `evt_valid` high is one accepted event. The mapped-number output is a one-cycle valid strobe with no ready. A consumer that cannot take one result per cycle must pace the events it sends.

Top module: `pci_irq_router`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `cpu_irq` and `map_vld` are 0. A reset in the middle of a run clears a high `cpu_irq`.
- R2: For slot 5, the mapped number is 32 plus the pin number modulo 4.
- R3: Slot 6 maps to 36 and slot 7 maps to 37, whatever the pin.
- R4: For slots 8 to 12, the mapped number is (slot − 8 + pin) + 38.
- R5: For any other slot, the mapped number equals the pin number. An event whose mapped number lies outside 32..63 leaves `cpu_irq` unchanged, and it also ends a pulse that is in progress.
- R6: If `edge_cfg[n−32]` is set for mapped number n, `cpu_irq` is 1 on exactly the cycle after the event and falls to 0 on the next cycle, unless another event arrives.
- R7: If that bit is clear, `cpu_irq` becomes `pol_cfg[n−32]` on the cycle after the event. It then holds that value, even when `pol_cfg` changes, until the next event that is not ignored.
- R8: The slot is bits 7:3 of `evt_devfn`. The function bits 2:0 have no effect on the mapping.
- R9: `evt_ready` is always 1. `map_vld` is 1 on exactly the cycle after each accepted event, and `map_num` then holds that event's mapped number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Interrupt event present this cycle |
| evt_ready | output | 1 | Event accepted; always 1 |
| evt_devfn | input | 8 | Device-function number; slot in bits 7:3 |
| evt_pin | input | 2 | Interrupt pin number, 0 to 3 |
| edge_cfg | input | 32 | Per-index trigger mode; 1 means pulse |
| pol_cfg | input | 32 | Per-index level driven when trigger mode is 0 |
| map_vld | output | 1 | Strobe: map_num holds a new result |
| map_num | output | 8 | Mapped interrupt number of the last event |
| cpu_irq | output | 1 | Registered CPU interrupt line |

## Verification
The checker reads the trigger-mode and polarity bits for an event as they stood on the clock edge that accepted it. It therefore assumes that software changes `edge_cfg` and `pol_cfg` only as plain register writes, with no further relation to the event stream. The pulse-drop check accepts a follow-on event in the next cycle as a valid reason for the line to stay high. The stimulus holds both configuration words constant during the table walk and changes polarity only in a directed test where no event is sent. Events are driven on the falling edge, so each one is held stable through the edge that accepts it.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;

  // Which row of the slot table an event falls into.
  typedef enum logic [2:0] {
    SC_SOUTH  = 3'd0,  // pin-indexed group of four
    SC_VIDEO  = 3'd1,  // single fixed number
    SC_NET    = 3'd2,  // single fixed number
    SC_EXPAND = 3'd3,  // rotating expansion slots
    SC_OTHER  = 3'd4   // untranslated
  } slot_class_e;

endpackage

// File: rtl/pci_irq_slot_map.sv
module pci_irq_slot_map
  import pci_irq_router_pkg::*;
#(
  parameter int DEVFN_W    = 8,
  parameter int PIN_W      = 2,
  parameter int NUM_W      = 8,
  parameter int CFG_W      = 32,
  parameter int IRQ_BASE   = 32,
  parameter int SLOT_LSB   = 3,
  parameter int SOUTH_SLOT = 5,
  parameter int VIDEO_SLOT = 6,
  parameter int NET_SLOT   = 7,
  parameter int EXP_FIRST  = 8,
  parameter int EXP_LAST   = 12,
  parameter int VIDEO_OFS  = 4,
  parameter int NET_OFS    = 5,
  parameter int EXP_OFS    = 6,
  localparam int SLOT_W    = DEVFN_W - SLOT_LSB,
  localparam int IDX_W     = $clog2(CFG_W)
) (
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [PIN_W-1:0]   pin,
  output logic [NUM_W-1:0]   num,
  output logic               idx_ok,
  output logic [IDX_W-1:0]   idx
);

  logic [SLOT_W-1:0] slot;
  slot_class_e       cls;
  logic [NUM_W-1:0]  rel;

  assign slot = devfn[DEVFN_W-1:SLOT_LSB];

  always_comb begin
    if (slot == SLOT_W'(SOUTH_SLOT))      cls = SC_SOUTH;
    else if (slot == SLOT_W'(VIDEO_SLOT)) cls = SC_VIDEO;
    else if (slot == SLOT_W'(NET_SLOT))   cls = SC_NET;
    else if (slot >= SLOT_W'(EXP_FIRST) && slot <= SLOT_W'(EXP_LAST))
                                          cls = SC_EXPAND;
    else                                  cls = SC_OTHER;
  end

  always_comb begin
    unique case (cls)
      SC_SOUTH:  num = NUM_W'(IRQ_BASE) + NUM_W'(pin[1:0]);
      SC_VIDEO:  num = NUM_W'(IRQ_BASE + VIDEO_OFS);
      SC_NET:    num = NUM_W'(IRQ_BASE + NET_OFS);
      SC_EXPAND: num = NUM_W'(slot) - NUM_W'(EXP_FIRST) + NUM_W'(pin)
                       + NUM_W'(EXP_OFS + IRQ_BASE);
      default:   num = NUM_W'(pin);
    endcase
  end

  assign rel    = num - NUM_W'(IRQ_BASE);
  assign idx_ok = (num >= NUM_W'(IRQ_BASE)) && (rel < NUM_W'(CFG_W));
  assign idx    = rel[IDX_W-1:0];

endmodule

// File: rtl/pci_irq_trigger.sv
module pci_irq_trigger #(
  parameter int CFG_W = 32,
  localparam int IDX_W = $clog2(CFG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             idx_ok,
  input  logic [IDX_W-1:0] idx,
  input  logic [CFG_W-1:0] edge_cfg,
  input  logic [CFG_W-1:0] pol_cfg,
  output logic             cpu_irq
);

  logic [CFG_W-1:0] hit;
  logic             edge_sel;
  logic             pol_sel;
  logic             take;
  logic             pulse_q;

  // One-hot decode of the internal index, one lane per config bit.
  for (genvar g = 0; g < CFG_W; g++) begin : g_lane
    assign hit[g] = idx_ok && (idx == IDX_W'(g));
  end

  assign edge_sel = |(hit & edge_cfg);
  assign pol_sel  = |(hit & pol_cfg);
  assign take     = fire && idx_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_irq <= 1'b0;
      pulse_q <= 1'b0;
    end else if (take) begin
      cpu_irq <= edge_sel | pol_sel;
      pulse_q <= edge_sel;
    end else if (pulse_q) begin
      cpu_irq <= 1'b0;
      pulse_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router #(
  parameter int DEVFN_W  = 8,
  parameter int PIN_W    = 2,
  parameter int NUM_W    = 8,
  parameter int CFG_W    = 32,
  parameter int IRQ_BASE = 32,
  parameter int SLOT_LSB = 3,
  localparam int IDX_W   = $clog2(CFG_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  output logic               evt_ready,
  input  logic [DEVFN_W-1:0] evt_devfn,
  input  logic [PIN_W-1:0]   evt_pin,
  input  logic [CFG_W-1:0]   edge_cfg,
  input  logic [CFG_W-1:0]   pol_cfg,
  output logic               map_vld,
  output logic [NUM_W-1:0]   map_num,
  output logic               cpu_irq
);

  logic [NUM_W-1:0] num_c;
  logic             idx_ok_c;
  logic [IDX_W-1:0] idx_c;
  logic             fire;

  assign evt_ready = 1'b1;
  assign fire      = evt_valid && evt_ready;

  pci_irq_slot_map #(
    .DEVFN_W (DEVFN_W),
    .PIN_W   (PIN_W),
    .NUM_W   (NUM_W),
    .CFG_W   (CFG_W),
    .IRQ_BASE(IRQ_BASE),
    .SLOT_LSB(SLOT_LSB)
  ) u_map (
    .devfn (evt_devfn),
    .pin   (evt_pin),
    .num   (num_c),
    .idx_ok(idx_ok_c),
    .idx   (idx_c)
  );

  pci_irq_trigger #(
    .CFG_W(CFG_W)
  ) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .idx_ok  (idx_ok_c),
    .idx     (idx_c),
    .edge_cfg(edge_cfg),
    .pol_cfg (pol_cfg),
    .cpu_irq (cpu_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_vld <= 1'b0;
      map_num <= '0;
    end else begin
      map_vld <= fire;
      if (fire) map_num <= num_c;
    end
  end

endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk #(
  parameter int DEVFN_W    = 8,
  parameter int PIN_W      = 2,
  parameter int NUM_W      = 8,
  parameter int CFG_W      = 32,
  parameter int IRQ_BASE   = 32,
  parameter int SLOT_LSB   = 3,
  parameter int SOUTH_SLOT = 5,
  parameter int VIDEO_SLOT = 6,
  localparam int IDX_W     = $clog2(CFG_W),
  localparam int SLOT_W    = DEVFN_W - SLOT_LSB
) (
  input logic               clk,
  input logic               rst_n,
  input logic               evt_valid,
  input logic               evt_ready,
  input logic [DEVFN_W-1:0] evt_devfn,
  input logic [PIN_W-1:0]   evt_pin,
  input logic [CFG_W-1:0]   edge_cfg,
  input logic [CFG_W-1:0]   pol_cfg,
  input logic               map_vld,
  input logic [NUM_W-1:0]   map_num,
  input logic               cpu_irq
);

  logic [CFG_W-1:0] edge_q;
  logic [CFG_W-1:0] pol_q;
  logic [NUM_W-1:0] rel;
  logic [IDX_W-1:0] ix;
  logic             in_rng;

  always_ff @(posedge clk) begin
    edge_q <= edge_cfg;
    pol_q  <= pol_cfg;
  end

  assign rel    = map_num - NUM_W'(IRQ_BASE);
  assign in_rng = (map_num >= NUM_W'(IRQ_BASE)) && (rel < NUM_W'(CFG_W));
  assign ix     = rel[IDX_W-1:0];

  a_r6_pulse_high: assert property (@(posedge clk) disable iff (!rst_n)
    (map_vld && in_rng && edge_q[ix]) |-> cpu_irq);

  a_r6_pulse_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (map_vld && in_rng && edge_q[ix]) |=> (!cpu_irq || map_vld));

  a_r7_level: assert property (@(posedge clk) disable iff (!rst_n)
    (map_vld && in_rng && !edge_q[ix]) |-> (cpu_irq == pol_q[ix]));

  a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> (map_vld && in_rng));

  a_r2_south: assert property (@(posedge clk) disable iff (!rst_n)
    (map_vld && ($past(evt_devfn[DEVFN_W-1:SLOT_LSB]) == SLOT_W'(SOUTH_SLOT)))
      |-> (map_num == NUM_W'(IRQ_BASE) + NUM_W'($past(evt_pin[1:0]))));

  a_r3_video: assert property (@(posedge clk) disable iff (!rst_n)
    (map_vld && ($past(evt_devfn[DEVFN_W-1:SLOT_LSB]) == SLOT_W'(VIDEO_SLOT)))
      |-> (map_num == NUM_W'(IRQ_BASE + 4)));

  a_r9_vld_cause: assert property (@(posedge clk) disable iff (!rst_n)
    map_vld |-> $past(evt_valid && evt_ready));

endmodule

bind pci_irq_router pci_irq_router_chk #(
  .DEVFN_W (DEVFN_W),
  .PIN_W   (PIN_W),
  .NUM_W   (NUM_W),
  .CFG_W   (CFG_W),
  .IRQ_BASE(IRQ_BASE),
  .SLOT_LSB(SLOT_LSB)
) u_chk (.*);

// File: tb/pci_irq_router_tb.sv
`timescale 1ns/100ps
module pci_irq_router_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic        evt_ready;
  logic [7:0]  evt_devfn;
  logic [1:0]  evt_pin;
  logic [31:0] edge_cfg;
  logic [31:0] pol_cfg;
  logic        map_vld;
  logic [7:0]  map_num;
  logic        cpu_irq;

  always #2.5 clk = ~clk;

  pci_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_devfn(evt_devfn), .evt_pin(evt_pin), .edge_cfg(edge_cfg),
    .pol_cfg(pol_cfg), .map_vld(map_vld), .map_num(map_num), .cpu_irq(cpu_irq)
  );

  // Pulse mode on indices 4,5 (slots 6,7); high polarity on 0,2,9,11.
  localparam logic [31:0] EDGE_CFG = 32'h0000_0030;
  localparam logic [31:0] POL_CFG  = 32'h0000_0A05;

  // {requirement, devfn, pin, expected mapped number}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {4'd2, 8'h28, 2'd0, 8'd32},  // R2 slot 5 pin 0
    {4'd2, 8'h28, 2'd1, 8'd33},  // R2
    {4'd8, 8'h2B, 2'd2, 8'd34},  // R8 slot 5, function 3
    {4'd2, 8'h28, 2'd3, 8'd35},  // R2
    {4'd3, 8'h30, 2'd2, 8'd36},  // R3 slot 6, pulse
    {4'd3, 8'h38, 2'd0, 8'd37},  // R3 slot 7, pulse
    {4'd4, 8'h40, 2'd0, 8'd38},  // R4 slot 8
    {4'd4, 8'h48, 2'd2, 8'd41},  // R4 slot 9
    {4'd4, 8'h60, 2'd3, 8'd45},  // R4 slot 12
    {4'd8, 8'h57, 2'd1, 8'd41},  // R8 slot 10, function 7
    {4'd4, 8'h58, 2'd2, 8'd43},  // R4 slot 11
    {4'd5, 8'h20, 2'd2, 8'd2},   // R5 slot 4 passthrough
    {4'd5, 8'h68, 2'd1, 8'd1},   // R5 slot 13 passthrough
    {4'd5, 8'h00, 2'd3, 8'd3}    // R5 slot 0 passthrough
  };

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  bit  model_irq = 1'b0;

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one event, check the result cycle and the cycle after it.
  task automatic send(logic [7:0] dv, logic [1:0] p, int exp_num, string req);
    int  ix;
    bit  ok;
    bit  edg;
    bit  exp_now;
    @(negedge clk);
    evt_devfn = dv; evt_pin = p; evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
    ix  = exp_num - 32;
    ok  = (ix >= 0) && (ix < 32);
    edg = ok && EDGE_CFG[ix];
    if (edg) begin
      exp_now = 1'b1; model_irq = 1'b0;
    end else if (ok) begin
      model_irq = POL_CFG[ix]; exp_now = model_irq;
    end else begin
      exp_now = model_irq;
    end
    check_eq("R9", "map_vld after event", int'(map_vld), 1);
    check_eq(req, "map_num", int'(map_num), exp_num);
    check_eq(edg ? "R6" : (ok ? "R7" : "R5"), "cpu_irq on result", int'(cpu_irq), int'(exp_now));
    @(negedge clk);
    check_eq(edg ? "R6" : (ok ? "R7" : "R5"), "cpu_irq one cycle later", int'(cpu_irq), int'(model_irq));
    check_eq("R9", "map_vld idle", int'(map_vld), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_devfn = '0; evt_pin = '0;
    edge_cfg = EDGE_CFG; pol_cfg = POL_CFG;
    repeat (3) @(negedge clk);
    check_eq("R1", "cpu_irq in reset", int'(cpu_irq), 0);
    check_eq("R1", "map_vld in reset", int'(map_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "cpu_irq after reset", int'(cpu_irq), 0);
    check_eq("R1", "map_vld after reset", int'(map_vld), 0);
    check_eq("R9", "evt_ready", int'(evt_ready), 1);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][17:10], VEC[i][9:8], int'(VEC[i][7:0]),
           $sformatf("R%0d", VEC[i][21:18]));
    end

    // R7: level held over idle cycles and over a polarity change with no event.
    send(8'h28, 2'd0, 32, "R2");
    repeat (4) @(negedge clk);
    check_eq("R7", "level held idle", int'(cpu_irq), 1);
    pol_cfg = 32'h0;
    repeat (2) @(negedge clk);
    check_eq("R7", "level held over pol change", int'(cpu_irq), 1);
    pol_cfg = POL_CFG;

    // R6: back-to-back pulse events keep the line up, then it drops.
    @(negedge clk);
    evt_devfn = 8'h30; evt_pin = 2'd0; evt_valid = 1'b1;
    @(negedge clk);
    evt_devfn = 8'h38;
    check_eq("R6", "first pulse", int'(cpu_irq), 1);
    @(negedge clk);
    evt_valid = 1'b0;
    check_eq("R6", "second pulse", int'(cpu_irq), 1);
    check_eq("R3", "slot 7 number", int'(map_num), 37);
    @(negedge clk);
    check_eq("R6", "line drops after pulses", int'(cpu_irq), 0);
    model_irq = 1'b0;

    // R5: an ignored event right after a pulse does not extend it.
    @(negedge clk);
    evt_devfn = 8'h30; evt_pin = 2'd1; evt_valid = 1'b1;
    @(negedge clk);
    evt_devfn = 8'h18; evt_pin = 2'd2;
    check_eq("R6", "pulse before ignored", int'(cpu_irq), 1);
    @(negedge clk);
    evt_valid = 1'b0;
    check_eq("R5", "ignored event ends pulse", int'(cpu_irq), 0);
    check_eq("R5", "ignored event number", int'(map_num), 2);

    // R1: reset in the middle of a run clears a high line.
    send(8'h48, 2'd2, 41, "R4");
    check_eq("R7", "line high before reset", int'(cpu_irq), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check_eq("R1", "mid-run reset clears cpu_irq", int'(cpu_irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "cpu_irq stays low after reset", int'(cpu_irq), 0);
    check_eq("R9", "evt_ready after reset", int'(evt_ready), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule